// File: doc/BRIEF.md
# Valid/Ready Channel Stability Monitor

This block is a passive observer for one channel that uses a VALID/READY handshake. It only listens to the handshake wires and the channel's payload bus, which carries address or data, strobes, response, last flag and ID as one flat vector. It never drives the channel. It reports two protocol violations. The first is the source withdrawing VALID before the transfer has been accepted. The second is any payload bit changing while the channel is stalled, meaning VALID is high and READY is low.

For each of the two rules there is a one-cycle pulse and a sticky flag. The pulse is asserted combinationally in the same cycle in which the offending values appear on the wires, so a bench can count violations and see the exact cycle. The sticky flag latches the violation until reset. A constant channel tag output carries the parameterised identity of the monitored channel, so that reports from many monitors can be merged. The monitor also counts completed transfers.

Top module: `vr_stability_monitor`

## Requirements
- R1: The transfer count increments by one on each rising edge where VALID and READY are both high, and holds otherwise. It wraps modulo 2^COUNT_W.
- R2: If the previous edge saw VALID high with READY low and VALID is now low, `withdrawnPulse` is high in that cycle.
- R3: If the previous edge saw VALID high with READY low, VALID is still high and the payload differs from the value sampled at that edge, `unstablePulse` is high in that cycle. It is never high while VALID is low.
- R4: The stability comparison covers every bit of the payload. Flipping any single bit while stalled raises `unstablePulse`.
- R5: `withdrawnSticky` and `unstableSticky` become high on the edge after their pulse and stay high until reset.
- R6: Each pulse lasts only for the cycle of the violation. A payload that changed once and then holds its new value while still stalled produces no further pulse.
- R7: While `rstN` is low, both sticky flags, both pulses and the transfer count are zero, whatever VALID, READY and payload do.
- R8: None of the following is a violation: VALID rising while READY is already high, payload changes while VALID is low, and a new payload in the cycle after a completed transfer.
- R9: `chanTag` equals the CHAN_ID parameter.
- R10: When a stalled payload changes in the same cycle that READY rises, both the unstable error and the transfer count update are reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Observed VALID of the channel |
| ready | input | 1 | Observed READY of the channel |
| payload | input | PAYLOAD_W | Observed payload bundle |
| withdrawnPulse | output | 1 | One-cycle flag: VALID dropped before acceptance |
| unstablePulse | output | 1 | One-cycle flag: payload changed while stalled |
| withdrawnSticky | output | 1 | Latched VALID-withdrawn error |
| unstableSticky | output | 1 | Latched payload-unstable error |
| xferCount | output | COUNT_W | Completed transfer count (wrapping) |
| chanTag | output | CHAN_W | Identity of the monitored channel |

## Verification
A completed transfer and a payload-stability error can occur in the same cycle. This happens when a stalled source changes its payload in exactly the cycle that READY rises. The bench provokes this for every payload bit with READY high at the moment of the change. It then judges that the unstable pulse is present in that cycle, and that on the next edge both the sticky flag and a transfer count of one appear. The same bit sweep with READY held low confirms that the error is raised without a count.

// File: rtl/vrmon_pkg.sv
package vrmon_pkg;

  // Strobes from the handshake control to the payload datapath
  typedef struct packed {
    logic capture;   // stalled now: hold payload for next compare
    logic compare;   // was stalled, VALID still high: check payload
    logic withdraw;  // was stalled, VALID gone: rule broken
    logic transfer;  // handshake completes on this edge
  } vrmon_strobe_t;

endpackage

// File: rtl/vrmon_ctrl.sv
module vrmon_ctrl
  import vrmon_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          valid,
  input  logic          ready,
  output vrmon_strobe_t strobes
);

  logic stalledQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stalledQ <= 1'b0;
    else       stalledQ <= valid && !ready;
  end

  always_comb begin
    strobes.capture  = valid && !ready;
    strobes.compare  = stalledQ && valid;
    strobes.withdraw = stalledQ && !valid;
    strobes.transfer = valid && ready;
  end

  // R2: a stall is always followed by either a compare or a withdraw decision
  assert_stall_followup_R2: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !ready) |=> (strobes.compare || strobes.withdraw));

  // R2: withdraw is only flagged when VALID was high on the previous edge
  assert_withdraw_after_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.withdraw |-> $past(valid));

endmodule

// File: rtl/vrmon_dp.sv
module vrmon_dp
  import vrmon_pkg::*;
#(
  parameter int PAYLOAD_W = 64,
  parameter int COUNT_W   = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  vrmon_strobe_t        strobes,
  input  logic [PAYLOAD_W-1:0] payload,
  output logic                 withdrawnPulse,
  output logic                 unstablePulse,
  output logic                 withdrawnSticky,
  output logic                 unstableSticky,
  output logic [COUNT_W-1:0]   xferCount
);

  localparam logic [COUNT_W-1:0] COUNT_ONE = COUNT_W'(1);

  logic [PAYLOAD_W-1:0] payloadQ;
  logic [PAYLOAD_W-1:0] diffBits;

  // Per-bit difference against the held payload
  for (genvar i = 0; i < PAYLOAD_W; i++) begin : g_diff
    assign diffBits[i] = payload[i] ^ payloadQ[i];
  end

  assign withdrawnPulse = strobes.withdraw;
  assign unstablePulse  = strobes.compare && (|diffBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      payloadQ        <= '0;
      withdrawnSticky <= 1'b0;
      unstableSticky  <= 1'b0;
      xferCount       <= '0;
    end else begin
      if (strobes.capture)  payloadQ <= payload;
      if (withdrawnPulse)   withdrawnSticky <= 1'b1;
      if (unstablePulse)    unstableSticky  <= 1'b1;
      if (strobes.transfer) xferCount <= xferCount + COUNT_ONE;
    end
  end

  assert_withdraw_latched_R5: assert property (@(posedge clk) disable iff (!rstN)
    withdrawnPulse |=> withdrawnSticky);
  assert_unstable_latched_R5: assert property (@(posedge clk) disable iff (!rstN)
    unstablePulse |=> unstableSticky);
  assert_withdraw_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    withdrawnSticky |=> withdrawnSticky);
  assert_unstable_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    unstableSticky |=> unstableSticky);
  assert_unstable_needs_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    unstablePulse |-> $past(strobes.capture));
  assert_rules_disjoint_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(unstablePulse && withdrawnPulse));
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.transfer |=> (xferCount == $past(xferCount) + COUNT_ONE));
  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.transfer |=> $stable(xferCount));

endmodule

// File: rtl/vr_stability_monitor.sv
module vr_stability_monitor
  import vrmon_pkg::*;
#(
  parameter int PAYLOAD_W = 64,
  parameter int COUNT_W   = 16,
  parameter int CHAN_W    = 4,
  parameter int CHAN_ID   = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 valid,
  input  logic                 ready,
  input  logic [PAYLOAD_W-1:0] payload,
  output logic                 withdrawnPulse,
  output logic                 unstablePulse,
  output logic                 withdrawnSticky,
  output logic                 unstableSticky,
  output logic [COUNT_W-1:0]   xferCount,
  output logic [CHAN_W-1:0]    chanTag
);

  vrmon_strobe_t strobes;

  assign chanTag = CHAN_W'(CHAN_ID);

  vrmon_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .valid   (valid),
    .ready   (ready),
    .strobes (strobes)
  );

  vrmon_dp #(
    .PAYLOAD_W (PAYLOAD_W),
    .COUNT_W   (COUNT_W)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .payload         (payload),
    .withdrawnPulse  (withdrawnPulse),
    .unstablePulse   (unstablePulse),
    .withdrawnSticky (withdrawnSticky),
    .unstableSticky  (unstableSticky),
    .xferCount       (xferCount)
  );

  // R7: outputs idle while reset is held
  always_comb begin
    if (!rstN) begin
      assert_reset_quiet_R7: assert (!withdrawnPulse && !unstablePulse);
    end
  end

endmodule

// File: tb/vr_stability_monitor_bench.sv
module vr_stability_monitor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int CW = 4;
  localparam int CHW = 4;
  localparam int CHID = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic valid = 1'b0;
  logic ready = 1'b0;
  logic [PW-1:0] payload = '0;
  logic withdrawnPulse, unstablePulse, withdrawnSticky, unstableSticky;
  logic [CW-1:0] xferCount;
  logic [CHW-1:0] chanTag;

  vr_stability_monitor #(
    .PAYLOAD_W (PW), .COUNT_W (CW), .CHAN_W (CHW), .CHAN_ID (CHID)
  ) u_vr_stability_monitor (
    .clk (clk), .rstN (rstN), .valid (valid), .ready (ready), .payload (payload),
    .withdrawnPulse (withdrawnPulse), .unstablePulse (unstablePulse),
    .withdrawnSticky (withdrawnSticky), .unstableSticky (unstableSticky),
    .xferCount (xferCount), .chanTag (chanTag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Model state derived from the requirements
  bit mStall = 0;
  bit mStickW = 0;
  bit mStickU = 0;
  logic [PW-1:0] mPay = '0;
  logic [CW-1:0] mCount = '0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle of channel values and check every output against the model
  task automatic apply(bit v, bit r, logic [PW-1:0] p);
    bit eW, eU;
    @(negedge clk);
    valid = v; ready = r; payload = p;
    #1;
    eW = mStall && !v;
    eU = mStall && v && (p != mPay);
    check(withdrawnPulse == eW, "R2", "withdrawnPulse", withdrawnPulse, eW);
    check(unstablePulse == eU, "R3", "unstablePulse", unstablePulse, eU);
    check(withdrawnSticky == mStickW, "R5", "withdrawnSticky", withdrawnSticky, mStickW);
    check(unstableSticky == mStickU, "R5", "unstableSticky", unstableSticky, mStickU);
    check(xferCount == mCount, "R1", "xferCount", xferCount, mCount);
    mStickW = mStickW | eW;
    mStickU = mStickU | eU;
    if (v && r) mCount = mCount + 1'b1;
    mStall = v && !r;
    if (v && !r) mPay = p;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; valid = 1'b1; ready = 1'b0; payload = 8'hA5;
    #1;
    check(!withdrawnPulse && !unstablePulse, "R7", "pulses in reset", {withdrawnPulse, unstablePulse}, 0);
    @(negedge clk);
    payload = 8'h5A; ready = 1'b1;
    #1;
    check(!unstablePulse && !withdrawnPulse, "R7", "pulses in reset", {withdrawnPulse, unstablePulse}, 0);
    check(!withdrawnSticky && !unstableSticky, "R7", "stickies in reset", {withdrawnSticky, unstableSticky}, 0);
    check(xferCount == 0, "R7", "count in reset", xferCount, 0);
    valid = 1'b0; ready = 1'b0;
    rstN = 1'b1;
    mStall = 0; mStickW = 0; mStickU = 0; mPay = '0; mCount = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pulseCount;
    doReset();
    check(chanTag == CHID, "R9", "chanTag", chanTag, CHID);

    // R8: legal traffic, no error expected
    apply(1, 1, 8'h11);
    apply(0, 0, 8'h22);
    apply(0, 0, 8'h33);
    apply(1, 0, 8'h44);
    apply(1, 1, 8'h44);
    apply(1, 0, 8'h55);
    apply(1, 1, 8'h55);
    apply(0, 1, 8'h66);
    apply(0, 0, 8'h00);
    check(!withdrawnSticky && !unstableSticky, "R8", "legal traffic stickies",
          {withdrawnSticky, unstableSticky}, 0);
    check(xferCount == 3, "R8", "legal transfers", xferCount, 3);

    // R4 / R10: every payload bit, with READY low and high at the change
    for (int b = 0; b < PW; b++) begin
      for (int r = 0; r < 2; r++) begin
        logic [PW-1:0] base;
        base = 8'h3C ^ PW'(b * 37);
        doReset();
        apply(1, 0, base);
        apply(1, 0, base);
        apply(1, r[0], base ^ (PW'(1) << b));
        check(unstablePulse == 1'b1, "R4", "bit flip pulse", unstablePulse, 1);
        apply(0, 0, base);
        check(unstableSticky == 1'b1, "R10", "sticky after change", unstableSticky, 1);
        check(xferCount == CW'(r), "R10", "count with change", xferCount, r);
      end
    end

    // R2 / R6: withdraw after stalls of several lengths
    for (int len = 1; len <= 4; len++) begin
      doReset();
      for (int k = 0; k < len; k++) apply(1, 0, 8'h77);
      apply(0, 0, 8'h00);
      check(withdrawnPulse == 1'b1, "R2", "withdraw pulse", withdrawnPulse, 1);
      apply(0, 0, 8'h00);
      check(withdrawnPulse == 1'b0, "R6", "withdraw pulse one cycle", withdrawnPulse, 0);
      check(withdrawnSticky == 1'b1, "R5", "withdraw sticky", withdrawnSticky, 1);
    end

    // R6: one pulse per change while the stall continues
    doReset();
    pulseCount = 0;
    apply(1, 0, 8'h0A); pulseCount += int'(unstablePulse);
    apply(1, 0, 8'h0B); pulseCount += int'(unstablePulse);
    apply(1, 0, 8'h0B); pulseCount += int'(unstablePulse);
    check(unstablePulse == 1'b0, "R6", "held new value no pulse", unstablePulse, 0);
    apply(1, 0, 8'h0C); pulseCount += int'(unstablePulse);
    apply(1, 1, 8'h0C); pulseCount += int'(unstablePulse);
    check(pulseCount == 2, "R6", "pulse count", pulseCount, 2);

    // R5: stickies survive legal traffic, then R7 clears them
    for (int k = 0; k < 5; k++) apply(1, 1, PW'(k));
    check(unstableSticky == 1'b1, "R5", "sticky holds", unstableSticky, 1);
    doReset();
    check(!unstableSticky, "R7", "sticky cleared", unstableSticky, 0);

    // R1: wrap of the transfer count, READY alone does not count
    for (int k = 0; k < 20; k++) apply(1, 1, PW'(k));
    apply(0, 1, 8'h00);
    apply(0, 0, 8'h00);
    check(xferCount == CW'(20), "R1", "count wrap", xferCount, 20 % 16);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule